// File: doc/BRIEF.md
# Barrel Shifter with Normalizer

This block is a combinational 32-bit shifter for floating-point normalization and for pulling bit fields out of a word. A 5-bit shift code always counts positions to the left. A mode input picks the variant. In rotate mode the word turns circularly, so any contiguous 16-bit field, wraparound included, can reach the output. In fill mode the direction input becomes the sign bit of a 6-bit two's-complement amount. A low direction gives a left shift that pulls in zeros. A high direction gives a right shift of 1 to 32 places that pulls in the sign input. Taken together, fill mode selects a 32-bit window out of the data word framed by 32 copies of the sign above and 32 zeros below.

A leading-digit encoder runs alongside the shifter. It XORs every data bit with the sign input, then reports how many left shifts bring the first significant bit up to bit 31. When normalization is requested, that count replaces the external shift code inside the block. One pass therefore left-aligns a two's-complement or unsigned mantissa.

The 32-bit result leaves the block 16 bits at a time: a half-select input picks the upper or the lower half. An active-low output enable gates the bus. The high-impedance state is represented by a cleared valid flag with the bus held at zero. The encoder count is driven whatever the output enable does.

Top module: `barrel_normalizer`

## Requirements
- R1: With an effective shift code of 0, in rotate mode or in fill mode with the direction low, the 32-bit result equals the data word.
- R2: In rotate mode (wrap_mode=1) the result is the data word rotated left by shift_code, and dir_right has no effect on it.
- R3: In fill mode (wrap_mode=0) with dir_right=0 the result is the data shifted left by shift_code (0 to 31), with zeros in the vacated low bits.
- R4: In fill mode with dir_right=1 the result is the data shifted right by 32 minus shift_code (1 to 32), with sign_in in the vacated high bits; code 0 gives a result that is all sign_in.
- R5: With upper_half=1, y_out carries result bits 31:16; with upper_half=0 it carries bits 15:0.
- R6: lead_code equals 31 minus the index of the highest bit where data_in differs from sign_in, so that a differing bit 31 gives 0.
- R7: When every data bit equals sign_in, lead_code is 31, the same value as when only bit 0 differs.
- R8: With norm_en=1, lead_code is used as the shift amount in place of shift_code, and shift_code has no effect on the result.
- R9: The shift result uses the raw data: in rotate mode and in fill mode with the direction low, sign_in has no effect on y_out.
- R10: With oe_n=1, y_valid is 0 and y_out is 0, while lead_code is still driven; with oe_n=0, y_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Data word to shift and to encode |
| sign_in | input | 1 | Fill value for right shifts; XOR mask ahead of the encoder |
| shift_code | input | 5 | Left-shift count (two's complement of the distance for a right shift) |
| dir_right | input | 1 | Fill convention in fill mode: 0 zero-fills the low bits, 1 sign-fills the high bits |
| wrap_mode | input | 1 | 1 rotates circularly, 0 shifts with fill |
| norm_en | input | 1 | 1 replaces shift_code with the encoder count |
| upper_half | input | 1 | Selects the upper (1) or lower (0) 16 result bits |
| oe_n | input | 1 | Active-low output enable |
| y_out | output | 16 | Selected result half, zero while disabled |
| y_valid | output | 1 | High while the output is enabled; low stands for high impedance |
| lead_code | output | 5 | Shift count that left-aligns the first significant bit |

## Verification
All 64 signed shift amounts are swept in both modes, with both sign values, both halves and both direction values. This is done for directed words and for random words. Words of all zeros and all ones separate zero fill from sign fill and rotation from shifting. A lone top or bottom bit and alternating patterns expose a rotate stage that is off by one place. A second run with the sign flipped shows that the sign reaches the fill positions only in a right shift. Directed encoder words place the first significant bit at the top, in the middle, at the bottom and nowhere. This separates the all-equal case from the lone-bit-0 case and catches a missing sign XOR. Normalization runs on random words and junk shift codes to show that the external code is ignored.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

    typedef enum logic [1:0] {
        FK_ROTATE    = 2'd0,
        FK_ZERO_LOW  = 2'd1,
        FK_SIGN_HIGH = 2'd2
    } fill_kind_e;

    function automatic fill_kind_e pick_fill(input logic wrap, input logic dir);
        if (wrap)
            return FK_ROTATE;
        else if (dir)
            return FK_SIGN_HIGH;
        else
            return FK_ZERO_LOW;
    endfunction

endpackage

// File: rtl/bns_lead_enc.sv
module bns_lead_enc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic          sign,
    output logic [CW-1:0] count
);
    logic [W-1:0] folded;

    assign folded = data ^ {W{sign}};

    // scan upward; the highest differing bit writes last and wins
    always_comb begin
        count = CW'(W - 1);
        for (int i = 0; i < W; i++) begin
            if (folded[i])
                count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/bns_shift_array.sv
module bns_shift_array
    import lsh_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [CW-1:0] amt,
    input  fill_kind_e    kind,
    input  logic          sign,
    output logic [W-1:0]  word
);
    logic [CW:0][W-1:0] stage;
    logic [W-1:0]       below;

    assign stage[0] = data;

    // logarithmic left rotator, one stage per code bit
    for (genvar s = 0; s < CW; s++) begin : g_rot
        localparam int K = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][W-1-K:0], stage[s][W-1 -: K]}
                                   : stage[s];
    end

    // thermometer: positions under the shift amount
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign below[i] = amt > CW'(i);
    end

    for (genvar i = 0; i < W; i++) begin : g_fill
        always_comb begin
            unique case (kind)
                FK_ROTATE:    word[i] = stage[CW][i];
                FK_ZERO_LOW:  word[i] = below[i] ? 1'b0 : stage[CW][i];
                FK_SIGN_HIGH: word[i] = below[i] ? stage[CW][i] : sign;
                default:      word[i] = stage[CW][i];
            endcase
        end
    end
endmodule

// File: rtl/bns_half_sel.sv
module bns_half_sel #(
    parameter int W = 32,
    parameter int H = W / 2
) (
    input  logic [W-1:0] word,
    input  logic         upper,
    output logic [H-1:0] half
);
    assign half = upper ? word[W-1 -: H] : word[H-1:0];
endmodule

// File: rtl/barrel_normalizer.sv
module barrel_normalizer
    import lsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = $clog2(DATA_W),
    parameter int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic              sign_in,
    input  logic [CODE_W-1:0] shift_code,
    input  logic              dir_right,
    input  logic              wrap_mode,
    input  logic              norm_en,
    input  logic              upper_half,
    input  logic              oe_n,
    output logic [HALF_W-1:0] y_out,
    output logic              y_valid,
    output logic [CODE_W-1:0] lead_code
);
    logic [CODE_W-1:0] eff_code;
    logic [DATA_W-1:0] shift_word;
    logic [HALF_W-1:0] half_word;
    fill_kind_e        kind;

    bns_lead_enc #(.W(DATA_W), .CW(CODE_W)) u_enc (
        .data  (data_in),
        .sign  (sign_in),
        .count (lead_code)
    );

    assign eff_code = norm_en ? lead_code : shift_code;
    assign kind     = pick_fill(wrap_mode, dir_right);

    bns_shift_array #(.W(DATA_W), .CW(CODE_W)) u_arr (
        .data (data_in),
        .amt  (eff_code),
        .kind (kind),
        .sign (sign_in),
        .word (shift_word)
    );

    bns_half_sel #(.W(DATA_W), .H(HALF_W)) u_half (
        .word  (shift_word),
        .upper (upper_half),
        .half  (half_word)
    );

    assign y_valid = ~oe_n;
    assign y_out   = oe_n ? '0 : half_word;
endmodule

// File: rtl/barrel_normalizer_chk.sv
module barrel_normalizer_chk #(
    parameter int W  = 32,
    parameter int CW = $clog2(W),
    parameter int H  = W / 2
) (
    input logic [W-1:0]  data_in,
    input logic          sign_in,
    input logic          dir_right,
    input logic          wrap_mode,
    input logic          norm_en,
    input logic          oe_n,
    input logic [H-1:0]  y_out,
    input logic [CW-1:0] lead_code,
    input logic [CW-1:0] eff_code,
    input logic [W-1:0]  shift_word
);
    logic [W-1:0] folded;
    assign folded = data_in ^ {W{sign_in}};

    always_comb begin
        if ((wrap_mode || !dir_right) && eff_code == '0)
            a_r1_identity: assert (shift_word == data_in)
                else $error("R1 zero code altered the word");
        if (!wrap_mode && dir_right && eff_code == '0)
            a_r4_all_sign: assert (shift_word == {W{sign_in}})
                else $error("R4 right shift by full width not all sign");
        if (folded[W-1])
            a_r6_top_bit: assert (lead_code == '0)
                else $error("R6 top bit differs but count nonzero");
        if (folded == '0)
            a_r7_all_equal: assert (lead_code == CW'(W - 1))
                else $error("R7 all-equal word not max count");
        if (norm_en && !wrap_mode && !dir_right && folded != '0)
            a_r8_normalized: assert (shift_word[W-1] == ~sign_in)
                else $error("R8 normalized word not left aligned");
        if (oe_n)
            a_r10_idle_bus: assert (y_out == '0)
                else $error("R10 disabled bus not idle");
    end
endmodule

bind barrel_normalizer barrel_normalizer_chk #(.W(DATA_W), .CW(CODE_W), .H(HALF_W)) u_chk (
    .data_in    (data_in),
    .sign_in    (sign_in),
    .dir_right  (dir_right),
    .wrap_mode  (wrap_mode),
    .norm_en    (norm_en),
    .oe_n       (oe_n),
    .y_out      (y_out),
    .lead_code  (lead_code),
    .eff_code   (eff_code),
    .shift_word (shift_word)
);

// File: tb/barrel_normalizer_test.sv
module barrel_normalizer_test;
    logic        clk = 1'b0;
    logic [31:0] data_in = '0;
    logic        sign_in = 1'b0;
    logic [4:0]  shift_code = '0;
    logic        dir_right = 1'b0;
    logic        wrap_mode = 1'b0;
    logic        norm_en = 1'b0;
    logic        upper_half = 1'b0;
    logic        oe_n = 1'b1;
    logic [15:0] y_out;
    logic        y_valid;
    logic [4:0]  lead_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cycles = 0;

    always #4 clk = ~clk;

    barrel_normalizer uut (
        .data_in    (data_in),
        .sign_in    (sign_in),
        .shift_code (shift_code),
        .dir_right  (dir_right),
        .wrap_mode  (wrap_mode),
        .norm_en    (norm_en),
        .upper_half (upper_half),
        .oe_n       (oe_n),
        .y_out      (y_out),
        .y_valid    (y_valid),
        .lead_code  (lead_code)
    );

    function automatic logic [31:0] ref_shift(logic [31:0] d, logic s, logic [4:0] c,
                                               logic dir, logic wrap);
        logic [95:0] ext;
        logic [63:0] dbl;
        int amt;
        if (wrap) begin
            dbl = {d, d} << c;
            return dbl[63:32];
        end
        ext = {{32{s}}, d, 32'h0};
        amt = dir ? int'(c) - 32 : int'(c);
        ext = ext >> (32 - amt);
        return ext[31:0];
    endfunction

    function automatic logic [4:0] ref_enc(logic [31:0] d, logic s);
        logic [31:0] x;
        x = d ^ {32{s}};
        for (int i = 31; i >= 0; i--)
            if (x[i]) return 5'(31 - i);
        return 5'd31;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    task automatic sweep(logic [31:0] d);
        logic [31:0] full;
        logic [15:0] hexp;
        string tag;
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 2; s++)
                for (int sc = 0; sc < 64; sc++)
                    for (int u = 0; u < 2; u++) begin
                        @(posedge clk);
                        data_in = d; sign_in = s[0]; wrap_mode = w[0];
                        dir_right = sc[5]; shift_code = sc[4:0];
                        upper_half = u[0]; norm_en = 1'b0; oe_n = 1'b0;
                        settle();
                        full = ref_shift(d, s[0], sc[4:0], sc[5], w[0]);
                        hexp = u[0] ? full[31:16] : full[15:0];
                        if (w[0]) tag = (sc[4:0] == 0) ? "R1/R2/R5" : "R2/R5";
                        else if (sc[5]) tag = "R4/R5";
                        else tag = (sc[4:0] == 0) ? "R1/R3/R5" : "R3/R5";
                        check(tag, 32'(y_out), 32'(hexp));
                        check("R6 sweep", 32'(lead_code), 32'(ref_enc(d, s[0])));
                    end
    endtask

    task automatic enc_case(logic [31:0] d, logic s, logic [4:0] exp, string tag);
        @(posedge clk);
        data_in = d; sign_in = s; norm_en = 1'b0;
        settle();
        check(tag, 32'(lead_code), 32'(exp));
    endtask

    initial begin
        logic [31:0] r;
        logic [31:0] full;
        logic [15:0] first;
        void'($urandom(32'd2024));

        // reset state: output disabled
        settle();
        check("R10 initial valid", 32'(y_valid), 32'd0);
        check("R10 initial bus", 32'(y_out), 32'd0);

        // directed encoder corners
        enc_case(32'h8000_0000, 1'b0, 5'd0,  "R6 top bit");
        enc_case(32'h7FFF_FFFF, 1'b1, 5'd0,  "R6 top differs from sign");
        enc_case(32'hFFFF_0000, 1'b1, 5'd16, "R6 sign xor middle");
        enc_case(32'h0000_0001, 1'b0, 5'd31, "R6 lone bit0");
        enc_case(32'h0000_0000, 1'b0, 5'd31, "R7 all zero");
        enc_case(32'hFFFF_FFFF, 1'b1, 5'd31, "R7 all ones negative");

        // output enable
        @(posedge clk);
        data_in = 32'h1234_5678; sign_in = 1'b0; wrap_mode = 1'b1;
        shift_code = 5'd4; oe_n = 1'b1; upper_half = 1'b1;
        settle();
        check("R10 disabled valid", 32'(y_valid), 32'd0);
        check("R10 disabled bus", 32'(y_out), 32'd0);
        check("R10 encoder driven", 32'(lead_code), 32'(ref_enc(32'h1234_5678, 1'b0)));
        @(posedge clk); oe_n = 1'b0;
        settle();
        check("R10 enabled valid", 32'(y_valid), 32'd1);

        // direction ignored in rotate mode, sign ignored in non-sign-fill shifts
        @(posedge clk);
        data_in = 32'hA5C3_0F81; wrap_mode = 1'b1; shift_code = 5'd9;
        dir_right = 1'b0; sign_in = 1'b0; upper_half = 1'b0;
        settle(); first = y_out;
        @(posedge clk); dir_right = 1'b1; sign_in = 1'b1;
        settle();
        check("R2 dir ignored in rotate", 32'(y_out), 32'(first));
        check("R9 raw data in rotate", 32'(y_out), 32'(first));
        @(posedge clk); wrap_mode = 1'b0; dir_right = 1'b0; sign_in = 1'b0;
        upper_half = 1'b1;
        settle(); first = y_out;
        @(posedge clk); sign_in = 1'b1;
        settle();
        check("R9 raw data in left fill", 32'(y_out), 32'(first));

        // full sweeps
        sweep(32'h0000_0000);
        sweep(32'hFFFF_FFFF);
        sweep(32'h8000_0000);
        sweep(32'h0000_0001);
        sweep(32'hA5A5_5A5A);
        for (int k = 0; k < 5; k++) sweep($urandom);

        // normalization replaces the external code
        for (int k = 0; k < 200; k++) begin
            r = $urandom >> ($urandom % 32);
            @(posedge clk);
            data_in = r; sign_in = k[0]; norm_en = 1'b1; wrap_mode = 1'b0;
            dir_right = 1'b0; shift_code = 5'($urandom); oe_n = 1'b0;
            upper_half = k[1];
            settle();
            full = ref_shift(r, k[0], ref_enc(r, k[0]), 1'b0, 1'b0);
            check("R8 normalize", 32'(y_out), 32'(k[1] ? full[31:16] : full[15:0]));
        end

        finish_run();
    end
endmodule